// File: doc/BRIEF.md
# Microprogram Sequencer with Digit-Compare Branch

This block drives the control side of a microprogrammed datapath. It keeps the micro program counter, reads a 128-word control store, and feeds the selected microinstruction to the datapath through a microinstruction register. Each microinstruction takes four clock cycles. A free-running phase counter marks these as fetch, latch, execute and write-back.

In the execute phase the sequencer forms the successor address (current address plus one) in a separate holding register. In the same cycle it evaluates the microinstruction's branch condition against flags that the datapath presents in that cycle. In the write-back phase the micro program counter takes either the held successor or the microinstruction's jump target.

Besides the usual "never", "if negative" and "always" conditions, one condition compares a decimal carry digit with a 4-bit test value. A chain of such microinstructions decodes a decimal opcode one value at a time.

The control store is computed from constants. The first five words form a fixed fetch/decode prologue. The remaining words follow an arithmetic rule, so the datapath word is exercised over many addresses and every branch kind occurs.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high reset sets `phase`, `mpc`, `s_latch` and every `mir_*` output to 0.
- R2: Outside reset, `phase` steps 0, 1, 2, 3 and then returns to 0, advancing once per clock.
- R3: The `mir_*` outputs take the control-store word at `mpc` on the clock edge that ends phase 0. They change on no other edge.
- R4: On the edge that ends phase 2, `s_latch` takes `mpc + 1`, and it holds at all other times.
- R5: Condition code 0 (`mir_cond` = 2'b00) never branches. On the edge that ends phase 3, `mpc` takes `s_latch`.
- R6: Condition code 1 branches only when `neg_flag` is high. With `neg_flag` low, execution falls through to the next address.
- R7: Condition code 2 branches only when `carry_digit` equals `mir_test`. After the prologue, a digit of 0 at address 4 sends `mpc` to 64.
- R8: Condition code 3 always branches. On the edge that ends phase 3, `mpc` takes `mir_addr`.
- R9: `mpc` changes only on the edge that ends phase 3.
- R10: The control-store contents are fixed as follows. Word 0 has ctrl 0x0000 and cond, test and target 0. Word 1 has ctrl 0x0804. Word 2 has ctrl 0x0018. Word 3 has ctrl 0x1068, cond 1 and target 9. Word 4 has ctrl 0x103A, cond 2, test 0 and target 64. Every other address a has ctrl (613a+29) mod 65536, cond a mod 4, test a mod 10 and target (3a+5) mod 128.
- R11: `neg_flag` and `carry_digit` are sampled only in phase 2. Their values in any other phase have no effect on `mpc`.
- R12: The successor address wraps: at `mpc` = 127, `s_latch` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| neg_flag | input | 1 | Negative flag from the datapath, used in phase 2 |
| carry_digit | input | 4 | Decimal carry-flag digit from the shifter, used in phase 2 |
| phase | output | 2 | Current phase of the four-cycle microinstruction (0..3) |
| mpc | output | 7 | Micro program counter |
| s_latch | output | 7 | Held successor address |
| mir_ctrl | output | 16 | Datapath control lines of the current microinstruction |
| mir_cond | output | 2 | Branch condition code |
| mir_test | output | 4 | Digit to compare against `carry_digit` |
| mir_addr | output | 7 | Branch target address |

## Verification
The run starts with both flags held at zero. This walks the fetch/decode prologue, separating a correct fall-through on a clear negative flag from a wrong branch, and checking the digit-match jump to 64.

After that, both flags change on every clock, including the three phases where they must be ignored. A design that samples them in the wrong phase therefore drifts away from the behavioural model.

A later stretch widens the digit to non-decimal values 10..15, which must never match a test value. A reset in mid-run checks that the sequencer restarts cleanly from any point in a microinstruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned USEQ_ADDR_W = 7;
    localparam int unsigned USEQ_CTRL_W = 16;
    localparam int unsigned USEQ_TEST_W = 4;
    localparam int unsigned USEQ_COND_W = 2;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_LATCH = 2'd1,
        PH_EXEC  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        BR_NEVER  = 2'b00,
        BR_NEG    = 2'b01,
        BR_DIGIT  = 2'b10,
        BR_ALWAYS = 2'b11
    } cond_e;

    // Datapath control word of control-store entry a
    function automatic logic [31:0] cs_ctrl(input int unsigned a);
        case (a)
            0: return 32'h0000_0000;
            1: return 32'h0000_0804;
            2: return 32'h0000_0018;
            3: return 32'h0000_1068;
            4: return 32'h0000_103A;
            default: return 32'((a * 613 + 29) % 65536);
        endcase
    endfunction

    function automatic logic [1:0] cs_cond(input int unsigned a);
        case (a)
            0, 1, 2: return BR_NEVER;
            3:       return BR_NEG;
            4:       return BR_DIGIT;
            default: return 2'(a % 4);
        endcase
    endfunction

    function automatic logic [3:0] cs_test(input int unsigned a);
        if (a <= 4) return 4'd0;
        return 4'(a % 10);
    endfunction

    function automatic logic [31:0] cs_target(input int unsigned a, input int unsigned depth);
        case (a)
            0, 1, 2: return 32'd0;
            3:       return 32'd9;
            4:       return 32'd64 % depth;
            default: return 32'((a * 3 + 5) % depth);
        endcase
    endfunction

endpackage

// File: rtl/useq_phase_gen.sv
module useq_phase_gen
    import useq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
        end else begin
            phase <= phase_e'(phase + 2'd1);
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase == phase_e'($past(phase) + 2'd1))) else $error("phase step"); // R2

endmodule

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
    import useq_pkg::*;
#(
    parameter int unsigned ADDR_W = USEQ_ADDR_W,
    parameter int unsigned CTRL_W = USEQ_CTRL_W
) (
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [CTRL_W-1:0]      rd_ctrl,
    output logic [USEQ_COND_W-1:0] rd_cond,
    output logic [USEQ_TEST_W-1:0] rd_test,
    output logic [ADDR_W-1:0]      rd_target
);

    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned WORD_W = CTRL_W + USEQ_COND_W + USEQ_TEST_W + ADDR_W;

    logic [WORD_W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [CTRL_W-1:0]      W_CTRL = CTRL_W'(cs_ctrl(i));
        localparam logic [USEQ_COND_W-1:0] W_COND = cs_cond(i);
        localparam logic [USEQ_TEST_W-1:0] W_TEST = cs_test(i);
        localparam logic [ADDR_W-1:0]      W_TGT  = ADDR_W'(cs_target(i, DEPTH));
        assign rom[i] = {W_CTRL, W_COND, W_TEST, W_TGT};
    end

    assign {rd_ctrl, rd_cond, rd_test, rd_target} = rom[rd_addr];

endmodule

// File: rtl/useq_branch_sel.sv
module useq_branch_sel
    import useq_pkg::*;
(
    input  logic [USEQ_COND_W-1:0] cond,
    input  logic                   neg,
    input  logic [USEQ_TEST_W-1:0] digit,
    input  logic [USEQ_TEST_W-1:0] test,
    output logic                   take
);

    always_comb begin
        case (cond_e'(cond))
            BR_NEVER:  take = 1'b0;
            BR_NEG:    take = neg;
            BR_DIGIT:  take = (digit == test);
            BR_ALWAYS: take = 1'b1;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int unsigned ADDR_W = USEQ_ADDR_W,
    parameter int unsigned CTRL_W = USEQ_CTRL_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   neg_flag,
    input  logic [USEQ_TEST_W-1:0] carry_digit,
    output logic [1:0]             phase,
    output logic [ADDR_W-1:0]      mpc,
    output logic [ADDR_W-1:0]      s_latch,
    output logic [CTRL_W-1:0]      mir_ctrl,
    output logic [USEQ_COND_W-1:0] mir_cond,
    output logic [USEQ_TEST_W-1:0] mir_test,
    output logic [ADDR_W-1:0]      mir_addr
);

    phase_e                   ph;
    logic [ADDR_W-1:0]        mpc_q;
    logic [ADDR_W-1:0]        succ_q;
    logic                     take_q;
    logic                     take_now;
    logic [CTRL_W-1:0]        ir_ctrl_q;
    logic [USEQ_COND_W-1:0]   ir_cond_q;
    logic [USEQ_TEST_W-1:0]   ir_test_q;
    logic [ADDR_W-1:0]        ir_tgt_q;
    logic [CTRL_W-1:0]        cs_ctrl_w;
    logic [USEQ_COND_W-1:0]   cs_cond_w;
    logic [USEQ_TEST_W-1:0]   cs_test_w;
    logic [ADDR_W-1:0]        cs_tgt_w;

    useq_phase_gen i_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (ph)
    );

    useq_ctrl_store #(
        .ADDR_W (ADDR_W),
        .CTRL_W (CTRL_W)
    ) i_store (
        .rd_addr   (mpc_q),
        .rd_ctrl   (cs_ctrl_w),
        .rd_cond   (cs_cond_w),
        .rd_test   (cs_test_w),
        .rd_target (cs_tgt_w)
    );

    useq_branch_sel i_branch (
        .cond  (ir_cond_q),
        .neg   (neg_flag),
        .digit (carry_digit),
        .test  (ir_test_q),
        .take  (take_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mpc_q     <= '0;
            succ_q    <= '0;
            take_q    <= 1'b0;
            ir_ctrl_q <= '0;
            ir_cond_q <= '0;
            ir_test_q <= '0;
            ir_tgt_q  <= '0;
        end else begin
            case (ph)
                PH_FETCH: begin
                    ir_ctrl_q <= cs_ctrl_w;
                    ir_cond_q <= cs_cond_w;
                    ir_test_q <= cs_test_w;
                    ir_tgt_q  <= cs_tgt_w;
                end
                PH_EXEC: begin
                    succ_q <= mpc_q + 1'b1;
                    take_q <= take_now;
                end
                PH_WRITE: begin
                    mpc_q <= take_q ? ir_tgt_q : succ_q;
                end
                default: ;
            endcase
        end
    end

    assign phase    = ph;
    assign mpc      = mpc_q;
    assign s_latch  = succ_q;
    assign mir_ctrl = ir_ctrl_q;
    assign mir_cond = ir_cond_q;
    assign mir_test = ir_test_q;
    assign mir_addr = ir_tgt_q;

    AST_MIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_FETCH) |=> ($stable(ir_ctrl_q) && $stable(ir_cond_q) && $stable(ir_tgt_q))) else $error("mir"); // R3
    AST_SUCC_INC: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EXEC) |=> (succ_q == $past(mpc_q) + 1'b1)) else $error("succ"); // R4
    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EXEC && ir_cond_q == BR_NEVER) |=> !take_q) else $error("never"); // R5
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EXEC && ir_cond_q == BR_ALWAYS) |=> take_q) else $error("always"); // R8
    AST_MPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_WRITE) |=> $stable(mpc_q)) else $error("mpc"); // R9
    AST_MPC_SELECT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WRITE) |=> (mpc_q == $past(ir_tgt_q) || mpc_q == $past(succ_q))) else $error("sel"); // R5

endmodule

// File: tb/test_useq_sequencer.sv
`timescale 1ns/1ps
module test_useq_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       neg_flag = 1'b0;
    logic [3:0] carry_digit = 4'd0;
    logic [1:0] phase;
    logic [6:0] mpc, s_latch, mir_addr;
    logic [15:0] mir_ctrl;
    logic [1:0] mir_cond;
    logic [3:0] mir_test;

    always #2.5 clk = ~clk;

    useq_sequencer i_useq_sequencer (
        .clk(clk), .rst(rst), .neg_flag(neg_flag), .carry_digit(carry_digit),
        .phase(phase), .mpc(mpc), .s_latch(s_latch), .mir_ctrl(mir_ctrl),
        .mir_cond(mir_cond), .mir_test(mir_test), .mir_addr(mir_addr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_ph = 0, m_mpc = 0, m_s = 0, m_take = 0;
    int m_ctrl = 0, m_cond = 0, m_test = 0, m_addr = 0;
    bit m_valid = 1'b0;
    int wrap_seen = 0;

    // control-store contents as given in R10
    function automatic int r10_ctrl(int a);
        int t[5] = '{0, 'h0804, 'h0018, 'h1068, 'h103A};
        if (a < 5) return t[a];
        return (613 * a + 29) % 65536;
    endfunction
    function automatic int r10_cond(int a);
        int t[5] = '{0, 0, 0, 1, 2};
        if (a < 5) return t[a];
        return a % 4;
    endfunction
    function automatic int r10_test(int a);
        return (a < 5) ? 0 : a % 10;
    endfunction
    function automatic int r10_addr(int a);
        int t[5] = '{0, 0, 0, 9, 64};
        if (a < 5) return t[a];
        return (3 * a + 5) % 128;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_mpc = 0; m_s = 0; m_take = 0;
            m_ctrl = 0; m_cond = 0; m_test = 0; m_addr = 0;
            m_valid = 1'b1;
        end else begin
            if (m_ph == 0) begin
                m_ctrl = r10_ctrl(m_mpc); m_cond = r10_cond(m_mpc);
                m_test = r10_test(m_mpc); m_addr = r10_addr(m_mpc);
            end else if (m_ph == 2) begin
                m_s = (m_mpc + 1) % 128;
                if (m_mpc == 127) wrap_seen++;
                case (m_cond)
                    0: m_take = 0;
                    1: m_take = int'(neg_flag);
                    2: m_take = (int'(carry_digit) == m_test) ? 1 : 0;
                    default: m_take = 1;
                endcase
            end else if (m_ph == 3) begin
                m_mpc = (m_take != 0) ? m_addr : m_s;
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        if (!m_valid) return;
        chk(int'(phase) == m_ph, "R2 phase", int'(phase), m_ph);
        chk(int'(mpc) == m_mpc, "R5 R6 R7 R8 R9 R11 mpc", int'(mpc), m_mpc);
        chk(int'(s_latch) == m_s, "R4 R12 s_latch", int'(s_latch), m_s);
        chk(int'(mir_ctrl) == m_ctrl, "R3 R10 mir_ctrl", int'(mir_ctrl), m_ctrl);
        chk(int'(mir_cond) == m_cond, "R3 R10 mir_cond", int'(mir_cond), m_cond);
        chk(int'(mir_test) == m_test, "R3 R10 mir_test", int'(mir_test), m_test);
        chk(int'(mir_addr) == m_addr, "R3 R10 mir_addr", int'(mir_addr), m_addr);
    endtask

    task automatic check_r1();
        chk(phase == 2'd0 && mpc == 7'd0 && s_latch == 7'd0, "R1 reset counters",
            int'(mpc) + int'(s_latch) + int'(phase), 0);
        chk(mir_ctrl == 16'd0 && mir_cond == 2'd0 && mir_test == 4'd0 && mir_addr == 7'd0,
            "R1 reset mir", int'(mir_ctrl) + int'(mir_addr), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    int unsigned rnd = 32'h2545_F491;
    function automatic int unsigned next_rnd(int unsigned x);
        int unsigned y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check_r1();
        rst = 1'b0;
        for (int cyc = 0; cyc < 8000; cyc++) begin
            @(negedge clk);
            compare_all();
            if (cyc == 15) chk(mpc == 7'd4, "R6 fall-through at 3", int'(mpc), 4);
            if (cyc == 19) chk(mpc == 7'd64, "R7 digit 0 jump", int'(mpc), 64);
            if (cyc == 4002) check_r1();
            rnd = next_rnd(rnd);
            if (cyc < 24) begin
                neg_flag = 1'b0;
                carry_digit = 4'd0;
            end else if (cyc < 3000) begin
                neg_flag = rnd[7];
                carry_digit = 4'(rnd[19:8] % 10);
            end else begin
                neg_flag = rnd[3];
                carry_digit = rnd[15:12];
            end
            rst = (cyc >= 4000 && cyc <= 4002);
        end
        // R12: successor wrap is exercised when address 127 is visited
        if (wrap_seen == 0) $display("note: R12 wrap not visited");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule